// File: doc/BRIEF.md
# Timer-Shared Bidirectional GPIO Port

This block is an 8-bit general-purpose port whose pins double as timer pins. Software uses a small byte-wide register bus to set a per-pin direction, to write output levels and to read pin levels. The timer gets a capture-edge strobe from each capture-capable pin. It drives output-compare levels onto selected pins through per-channel enables, and each enabled compare takes the pin even when the pin is set as an input.

Pin 3 is shared. A control bit makes it either a fifth compare output or a fourth capture input. A 16-bit register belongs to that shared channel. In compare mode software reads and writes it freely, and its value goes to the external compare logic. In capture mode it loads the free-running counter value on each pin-3 edge, and it ignores bus writes. Pins driven as outputs still loop back through the pad into the capture path and into the pulse-accumulator input. A software write that toggles an output pin is therefore seen as a capture edge.

Top module: `tmr_gpio_port`

## Requirements
- R1: The direction register (address 1, bit n for pin n) resets to 0. A 0 bit makes the pin an input and a 1 bit makes it an output. With no compare enabled, `pin_oe` equals the direction register.
- R2: The data register sits at address 0, with bit n for pin n. Writes always update the latch, and `pin_out` presents the latch. A read returns the latch bit for an output pin. For an input pin it returns the pin level seen through a two-flop synchronizer, so the new level reads back from the second clock edge after it is applied.
- R3: While `rst_n` is low and the clock runs, the data latch follows the synchronized pin levels. After release the latch holds the pin levels sampled during reset.
- R4: Control register address 2, bit 0, resets to 0. A 0 makes pin 3 the fifth compare output, and no capture strobe comes from pin 3. A 1 makes pin 3 the fourth capture input.
- R5: Any edge, rising or falling, on pins 0, 1 and 2 gives a one-cycle pulse on `ic_strobe[0]`, `[1]` and `[2]`. An edge on pin 3 in capture mode pulses `ic_strobe[3]` the same way. The pulse is high in the cycle after the second clock edge following the edge. It fires whether the edge comes from outside or from the pin's own output.
- R6: On an `ic_strobe[3]` pulse the shared register loads `cnt_value` at the next clock edge. The register reads back at address 4 (high byte) and address 5 (low byte).
- R7: In capture mode, bus writes to addresses 4 and 5 leave the shared register unchanged.
- R8: In compare mode, writes to address 4 and address 5 update the high byte and the low byte. `cc_value` always shows the register, and the register resets to 0.
- R9: `oc_en[0]` drives pin 6, `oc_en[1]` pin 5 and `oc_en[2]` pin 4. `oc_en[3]` drives pin 3, in compare mode only. While enabled, the pin outputs the matching `oc_val` bit with output enable high, whatever its direction bit.
- R10: Bit k of `oc1_en` drives pin k+3 with `oc1_val[k]` and output enable high. This takes priority over the other compare channels and the latch.
- R11: `pa_level` is the synchronized level of pin 7. It follows the pin even when pin 7 is an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| ic_strobe | output | 4 | Capture-edge pulses to the timer |
| pa_level | output | 1 | Synchronized pin 7 level for the pulse accumulator |
| cnt_value | input | 16 | Timer counter value to capture |
| cc_value | output | 16 | Shared capture/compare register value |
| oc_en | input | 4 | Compare drive enables: OC2, OC3, OC4, OC5 |
| oc_val | input | 4 | Compare drive levels, same order |
| oc1_en | input | 5 | Compare-1 drive enables for pins 3 to 7 |
| oc1_val | input | 5 | Compare-1 drive levels for pins 3 to 7 |

## Verification
A wrong direction or latch bit shows on `pin_oe` or `pin_out` in the cycle after the bus write. A fault in the synchronizer or the edge detector shows as a strobe that is missing, too long or off by a cycle, two edges after the pin moves. A fault in the mode bit or the shared register shows at the ports in one of three ways. Pin 3 drives or strobes in the wrong mode. `cc_value` changes after a write in capture mode. Or the captured count differs from the count present on the strobe cycle.

// File: rtl/tgp_pkg.sv
package tgp_pkg;
  localparam int PORT_W   = 8;
  localparam int BUS_W    = 8;
  localparam int CNT_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_IC   = 4;
  localparam int NUM_OC   = 4;
  localparam int OC1_BASE = 3;
  localparam int OC1_PINS = PORT_W - OC1_BASE;
  localparam int SHR_PIN  = 3;
  localparam int PA_PIN   = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_DIR   = 3'd1,
    A_CTRL  = 3'd2,
    A_CC_HI = 3'd4,
    A_CC_LO = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tgp_sync_edge.sv
module tgp_sync_edge #(
  parameter int W  = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  lvl,
  output logic [EW-1:0] chg
);
  logic [W-1:0]  s1_q, s2_q;
  logic [EW-1:0] s3_q;

  // Sampling flops: no reset, they only ever hold pad levels
  always_ff @(posedge clk) begin
    s1_q <= d;
    s2_q <= s1_q;
    s3_q <= s2_q[EW-1:0];
  end

  assign lvl = s2_q;
  assign chg = s2_q[EW-1:0] ^ s3_q;
endmodule

// File: rtl/tgp_regs.sv
module tgp_regs
  import tgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_reset,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PORT_W-1:0] pin_lvl,
  input  logic              cap_load,
  input  logic [CNT_W-1:0]  cnt_value,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic              cap_sel,
  output logic [CNT_W-1:0]  cc_q
);
  logic              wr;
  logic              latch_en, dir_en, ctrl_en, cc_en;
  logic [PORT_W-1:0] latch_d;
  logic [CNT_W-1:0]  cc_d;

  assign wr = bus_sel & bus_wr;

  always_comb begin
    latch_en = in_reset | (wr && bus_addr == A_DATA);
    latch_d  = in_reset ? pin_lvl : bus_wdata;
    dir_en   = wr && bus_addr == A_DIR;
    ctrl_en  = wr && bus_addr == A_CTRL;
    cc_en    = cap_load;
    cc_d     = cnt_value;
    if (!cap_load && !cap_sel && wr && bus_addr == A_CC_HI) begin
      cc_en = 1'b1;
      cc_d  = {bus_wdata, cc_q[BUS_W-1:0]};
    end else if (!cap_load && !cap_sel && wr && bus_addr == A_CC_LO) begin
      cc_en = 1'b1;
      cc_d  = {cc_q[CNT_W-1:BUS_W], bus_wdata};
    end
  end

  // Latch carries no reset value: it samples the pads while reset is held
  always_ff @(posedge clk) begin
    if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      cap_sel <= 1'b0;
      cc_q    <= '0;
    end else begin
      if (dir_en)  dir_q   <= bus_wdata;
      if (ctrl_en) cap_sel <= bus_wdata[0];
      if (cc_en)   cc_q    <= cc_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:  bus_rdata = (dir_q & latch_q) | (~dir_q & pin_lvl);
      A_DIR:   bus_rdata = dir_q;
      A_CTRL:  bus_rdata = {{(BUS_W-1){1'b0}}, cap_sel};
      A_CC_HI: bus_rdata = cc_q[CNT_W-1:BUS_W];
      A_CC_LO: bus_rdata = cc_q[BUS_W-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tgp_pinmux.sv
module tgp_pinmux
  import tgp_pkg::*;
(
  input  logic [PORT_W-1:0]   latch_q,
  input  logic [PORT_W-1:0]   dir_q,
  input  logic                cap_sel,
  input  logic [NUM_OC-1:0]   oc_en,
  input  logic [NUM_OC-1:0]   oc_val,
  input  logic [OC1_PINS-1:0] oc1_en,
  input  logic [OC1_PINS-1:0] oc1_val,
  output logic [PORT_W-1:0]   pin_out,
  output logic [PORT_W-1:0]   pin_oe
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic one_en, one_val, m_en, m_val;
    // Single compare channel owning this pin (pins 6..3 <- channel 0..3)
    if (i == SHR_PIN) begin : g_shr
      assign one_en  = oc_en[NUM_OC-1] & ~cap_sel;
      assign one_val = oc_val[NUM_OC-1];
    end else if (i > SHR_PIN && i < PA_PIN) begin : g_one
      assign one_en  = oc_en[6-i];
      assign one_val = oc_val[6-i];
    end else begin : g_none
      assign one_en  = 1'b0;
      assign one_val = 1'b0;
    end
    // Compare 1 may reach every pin from OC1_BASE upward
    if (i >= OC1_BASE) begin : g_m
      assign m_en  = oc1_en[i-OC1_BASE];
      assign m_val = oc1_val[i-OC1_BASE];
    end else begin : g_nom
      assign m_en  = 1'b0;
      assign m_val = 1'b0;
    end
    always_comb begin
      if (m_en) begin
        pin_out[i] = m_val;
        pin_oe[i]  = 1'b1;
      end else if (one_en) begin
        pin_out[i] = one_val;
        pin_oe[i]  = 1'b1;
      end else begin
        pin_out[i] = latch_q[i];
        pin_oe[i]  = dir_q[i];
      end
    end
  end
endmodule

// File: rtl/tmr_gpio_port.sv
module tmr_gpio_port
  import tgp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [PORT_W-1:0]   pin_in,
  output logic [PORT_W-1:0]   pin_out,
  output logic [PORT_W-1:0]   pin_oe,
  output logic [NUM_IC-1:0]   ic_strobe,
  output logic                pa_level,
  input  logic [CNT_W-1:0]    cnt_value,
  output logic [CNT_W-1:0]    cc_value,
  input  logic [NUM_OC-1:0]   oc_en,
  input  logic [NUM_OC-1:0]   oc_val,
  input  logic [OC1_PINS-1:0] oc1_en,
  input  logic [OC1_PINS-1:0] oc1_val
);
  logic              in_reset_q;
  logic [PORT_W-1:0] lvl, latch_q, dir_q;
  logic [NUM_IC-1:0] chg;
  logic              cap_sel;

  // Set by reset, cleared on the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_reset_q <= 1'b1;
    else        in_reset_q <= 1'b0;
  end

  tgp_sync_edge #(.W(PORT_W), .EW(NUM_IC)) i_sync (
    .clk (clk),
    .d   (pin_in),
    .lvl (lvl),
    .chg (chg)
  );

  assign ic_strobe[NUM_IC-2:0] = chg[NUM_IC-2:0] & ~{(NUM_IC-1){in_reset_q}};
  assign ic_strobe[NUM_IC-1]   = chg[NUM_IC-1] & cap_sel & ~in_reset_q;
  assign pa_level              = lvl[PA_PIN];

  tgp_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_reset  (in_reset_q),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_lvl   (lvl),
    .cap_load  (ic_strobe[NUM_IC-1]),
    .cnt_value (cnt_value),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .cap_sel   (cap_sel),
    .cc_q      (cc_value)
  );

  tgp_pinmux i_mux (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .cap_sel (cap_sel),
    .oc_en   (oc_en),
    .oc_val  (oc_val),
    .oc1_en  (oc1_en),
    .oc1_val (oc1_val),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/tgp_checker.sv
module tgp_checker
  import tgp_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [PORT_W-1:0]   pin_out,
  input logic [PORT_W-1:0]   pin_oe,
  input logic [NUM_IC-1:0]   ic_strobe,
  input logic [CNT_W-1:0]    cnt_value,
  input logic [CNT_W-1:0]    cc_value,
  input logic [NUM_OC-1:0]   oc_en,
  input logic [NUM_OC-1:0]   oc_val,
  input logic [OC1_PINS-1:0] oc1_en,
  input logic [OC1_PINS-1:0] oc1_val,
  input logic [PORT_W-1:0]   dir_q,
  input logic                cap_sel
);
  assert_dir_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (oc1_en == '0 && oc_en == '0) |-> pin_oe == dir_q);

  assert_ic4_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ic_strobe[NUM_IC-1] |-> cap_sel);

  assert_cap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ic_strobe[NUM_IC-1] |=> cc_value == $past(cnt_value));

  assert_cap_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_sel && bus_sel && bus_wr && bus_addr[2] && !ic_strobe[NUM_IC-1])
      |=> $stable(cc_value));

  assert_oc5_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_sel && oc_en[NUM_OC-1] && !oc1_en[0])
      |-> (pin_oe[SHR_PIN] && pin_out[SHR_PIN] == oc_val[NUM_OC-1]));

  assert_oc1_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oc1_en != '0) |-> (((pin_oe[PORT_W-1:OC1_BASE] & oc1_en) == oc1_en) &&
                        ((pin_out[PORT_W-1:OC1_BASE] & oc1_en) == (oc1_val & oc1_en))));
endmodule

bind tmr_gpio_port tgp_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .ic_strobe (ic_strobe),
  .cnt_value (cnt_value),
  .cc_value  (cc_value),
  .oc_en     (oc_en),
  .oc_val    (oc_val),
  .oc1_en    (oc1_en),
  .oc1_val   (oc1_val),
  .dir_q     (dir_q),
  .cap_sel   (cap_sel)
);

// File: tb/test_tmr_gpio_port.sv
module test_tmr_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, ext;
  logic [3:0]  ic_strobe, oc_en, oc_val;
  logic        pa_level;
  logic [15:0] cnt_value, cc_value;
  logic [4:0]  oc1_en, oc1_val;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  rd;

  always #2.5 clk = ~clk;

  // Pad model: a driven pin reads back its own output
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  tmr_gpio_port i_tmr_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ic_strobe(ic_strobe), .pa_level(pa_level), .cnt_value(cnt_value),
    .cc_value(cc_value), .oc_en(oc_en), .oc_val(oc_val),
    .oc1_en(oc1_en), .oc1_val(oc1_val));

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    ext = 8'hA5; cnt_value = 0; oc_en = 0; oc_val = 0; oc1_en = 0; oc1_val = 0;
    repeat (6) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset pin_oe", pin_oe, 8'h00);
    bus_read(3'd1, rd); check("R1 reset dir", rd, 8'h00);
    bus_read(3'd2, rd); check("R4 reset ctrl", rd, 8'h00);
    check("R8 reset cc_value", cc_value, 16'h0000);
  endtask

  task automatic t_reset_latch();
    ext = 8'h00;
    bus_write(3'd1, 8'hFF);
    bus_read(3'd0, rd);  check("R3 latch from reset pins", rd, 8'hA5);
    check("R3 pin_out after reset", pin_out, 8'hA5);
  endtask

  task automatic t_mixed_dir();
    bus_write(3'd1, 8'h0F);
    bus_write(3'd0, 8'h3C);
    ext = 8'h90;
    check("R1 oe follows dir", pin_oe, 8'h0F);
    check("R2 pin_out low nibble", pin_out[3:0], 4'hC);
    tick(); tick();
    bus_read(3'd0, rd);  check("R2 mixed read", rd, 8'h9C);
  endtask

  task automatic t_sync_latency();
    bus_write(3'd1, 8'h00);
    ext = 8'h00; repeat (3) tick();
    ext = 8'h81; tick();
    bus_read(3'd0, rd);  check("R2 one edge old level", rd, 8'h00);
    tick();
    bus_read(3'd0, rd);  check("R2 two edges new level", rd, 8'h81);
  endtask

  task automatic t_edge_input();
    repeat (2) tick();
    ext = 8'h83; tick();
    check("R5 no early strobe", ic_strobe, 4'h0);
    tick();
    check("R5 rising strobe pin1", ic_strobe, 4'b0010);
    tick();
    check("R5 strobe one cycle", ic_strobe, 4'h0);
    ext = 8'h81; tick(); tick();
    check("R5 falling strobe pin1", ic_strobe, 4'b0010);
  endtask

  task automatic t_edge_loopback();
    bus_write(3'd1, 8'h04);
    bus_write(3'd0, 8'h00);
    repeat (3) tick();
    bus_write(3'd0, 8'h04);
    tick(); tick();
    check("R5 loopback strobe pin2", ic_strobe, 4'b0100);
  endtask

  task automatic t_capture();
    bus_write(3'd1, 8'h0C);
    repeat (3) tick();
    bus_write(3'd0, 8'h0C);
    tick(); tick();
    check("R4 no pin3 strobe in compare mode", ic_strobe[3], 1'b0);
    bus_write(3'd2, 8'h01);
    bus_read(3'd2, rd); check("R4 ctrl readback", rd, 8'h01);
    cnt_value = 16'h1234;
    repeat (2) tick();
    bus_write(3'd0, 8'h04);
    tick(); tick();
    check("R5 pin3 strobe in capture mode", ic_strobe[3], 1'b1);
    tick();
    cnt_value = 16'h5678;
    check("R6 captured cc_value", cc_value, 16'h1234);
    bus_read(3'd4, rd); check("R6 high byte", rd, 8'h12);
    bus_read(3'd5, rd); check("R6 low byte", rd, 8'h34);
  endtask

  task automatic t_cap_nowrite();
    bus_write(3'd4, 8'hFF);
    bus_write(3'd5, 8'hEE);
    check("R7 write ignored cc_value", cc_value, 16'h1234);
    bus_read(3'd5, rd); check("R7 low byte unchanged", rd, 8'h34);
  endtask

  task automatic t_cmp_write();
    bus_write(3'd2, 8'h00);
    bus_write(3'd4, 8'hAB);
    bus_write(3'd5, 8'hCD);
    check("R8 compare value", cc_value, 16'hABCD);
    bus_read(3'd4, rd); check("R8 high readback", rd, 8'hAB);
  endtask

  task automatic t_oc_drive();
    bus_write(3'd1, 8'h00);
    bus_write(3'd0, 8'h00);
    oc_en = 4'b0001; oc_val = 4'b0001; #1;
    check("R9 OC2 on pin6", {pin_oe[6], pin_out[6]}, 2'b11);
    oc_en = 4'b0100; oc_val = 4'b0000; #1;
    check("R9 OC4 on pin4", {pin_oe[4], pin_out[4]}, 2'b10);
    oc_en = 4'b1000; oc_val = 4'b1000; #1;
    check("R9 OC5 on pin3", {pin_oe[3], pin_out[3]}, 2'b11);
    bus_write(3'd2, 8'h01);
    check("R9 OC5 off in capture mode", pin_oe[3], 1'b0);
    bus_write(3'd2, 8'h00);
    oc_en = 4'b0001; oc_val = 4'b0001;
    oc1_en = 5'b11000; oc1_val = 5'b10000; #1;
    check("R10 OC1 overrides OC2 pin6", {pin_oe[6], pin_out[6]}, 2'b10);
    check("R10 OC1 on pin7", {pin_oe[7], pin_out[7]}, 2'b11);
    oc_en = 0; oc_val = 0; oc1_en = 0; oc1_val = 0;
    tick();
  endtask

  task automatic t_pulse_acc();
    ext = 8'h00;
    bus_write(3'd1, 8'h80);
    bus_write(3'd0, 8'h80);
    tick(); tick();
    check("R11 pa_level from output pin7", pa_level, 1'b1);
    bus_write(3'd0, 8'h00);
    tick(); tick();
    check("R11 pa_level follows pin7 low", pa_level, 1'b0);
  endtask

  initial begin
    t_reset();
    t_reset_latch();
    t_mixed_dir();
    t_sync_latency();
    t_edge_input();
    t_edge_loopback();
    t_capture();
    t_cap_nowrite();
    t_cmp_write();
    t_oc_drive();
    t_pulse_acc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule